// File: doc/BRIEF.md
# Reorder Buffer with Precise Flush

This block keeps instructions of an out-of-order core in program order between dispatch and retirement. Each dispatched instruction takes the slot at the tail of a circular buffer; the block records the instruction's destination architectural register and hands back a rename tag. The tag is the slot number plus one, so a tag of zero can stand for "no producer" in the rename map. Execution units report results on one shared result bus as a tag, a value and an exception flag. The block stores the value in the matching slot and marks the slot done.

Each cycle the oldest slot is examined. If it is not yet done, nothing leaves the buffer, even when younger slots are done. If it is done cleanly, its register identifier, value and tag are presented on registered retire outputs for the register file and the rename map, and the slot is freed. If it is done with an exception, the block raises a one-cycle flush pulse and empties every slot. The pointers return to the start so the core can restart from the faulting instruction.

Top module: `reorder_buf`

## Requirements
- R1: After synchronous reset, disp_ready is 1, disp_tag is 1, ret_valid is 0 and flush is 0.
- R2: A dispatch with disp_valid high while disp_ready is high allocates the slot named by disp_tag. disp_tag then advances by one, and it wraps from DEPTH back to 1.
- R3: disp_ready is low exactly when DEPTH slots are occupied, and a dispatch attempted while it is low changes nothing.
- R4: A result with cmp_valid high and cmp_tag in 1..DEPTH naming an occupied slot stores cmp_value in that slot and marks it done. That value is the one later presented on ret_value.
- R5: When the oldest slot is done without exception, the next cycle shows ret_valid high for one cycle with that slot's tag, destination register and value. Tags retire in allocation order, at most one per cycle.
- R6: While the oldest slot is not done, ret_valid stays low whatever the state of younger slots.
- R7: When the oldest slot is done with cmp_exc set, the next cycle shows flush high and ret_valid low. Every slot is emptied, so disp_tag reads 1 and disp_ready reads 1.
- R8: A dispatch or a result presented in the same cycle as the edge that performs a flush is discarded.
- R9: A dispatch accepted in the same cycle as a retirement leaves the occupancy unchanged. A retirement out of the full state raises disp_ready on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination architectural register of the dispatched instruction |
| disp_ready | output | 1 | A free slot exists; dispatch is accepted |
| disp_tag | output | TAG_W | Tag the next accepted dispatch receives (1..DEPTH) |
| cmp_valid | input | 1 | Result bus carries a result |
| cmp_tag | input | TAG_W | Tag of the producing instruction |
| cmp_value | input | DATA_W | Result value |
| cmp_exc | input | 1 | Producing instruction raised an exception |
| ret_valid | output | 1 | One slot retired in the previous cycle |
| ret_tag | output | TAG_W | Tag of the retired slot |
| ret_dest | output | REG_W | Destination register to write |
| ret_value | output | DATA_W | Value to write into the register file |
| flush | output | 1 | One-cycle pulse: machine cleared because of an exception |

## Verification
Dispatch and retirement can fall on the same clock edge, and the occupancy must come out unchanged. A flush can fall on the same edge as a dispatch and a result, and both of those must be lost. The bench forces the first case with a directed run near the full state: it completes the oldest slot and then dispatches in the cycle the retirement fires. It judges the outcome by disp_ready and disp_tag on the next cycles. It forces the second case by completing the oldest slot with an exception and then presenting a dispatch and a result together in the flush cycle. It expects disp_tag back at 1 and no later retirement. Long random runs mix both collisions freely against a bench model of the slot states.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;

  // Decision taken for the oldest slot in a cycle
  typedef enum logic [1:0] {
    HEAD_HOLD   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_FLUSH  = 2'd2
  } head_act_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  head_act_e        act,
  output logic [IDX_W-1:0] head_q,
  output logic [IDX_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q,
  output logic             full_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             retire;
  logic [CNT_W-1:0] count_nxt;
  logic [IDX_W-1:0] head_nxt;
  logic [IDX_W-1:0] tail_nxt;

  assign retire = (act == HEAD_RETIRE);

  always_comb begin
    head_nxt  = (head_q == LAST_IDX) ? '0 : head_q + IDX_W'(1);
    tail_nxt  = (tail_q == LAST_IDX) ? '0 : tail_q + IDX_W'(1);
    count_nxt = count_q + CNT_W'(alloc) - CNT_W'(retire);
  end

  always_ff @(posedge clk) begin
    if (rst || act == HEAD_FLUSH) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (retire) head_q <= head_nxt;
      if (alloc)  tail_q <= tail_nxt;
      count_q <= count_nxt;
      full_q  <= (count_nxt == FULL_CNT);
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT);

  // R2
  full_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == FULL_CNT) |-> (head_q == tail_q));

endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              alloc,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              cmp_we,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              release_head,
  input  logic [IDX_W-1:0]  head_idx,
  output logic              head_live,
  output logic              head_done,
  output logic              head_exc,
  output logic [REG_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_value
);

  logic [DEPTH-1:0]  live_q;
  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  exc_q;
  logic [REG_W-1:0]  dest_mem [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic              cmp_hit;

  assign cmp_hit = cmp_we && live_q[cmp_idx];

  // Payload arrays: one write port each, no reset, so they map to RAM
  always_ff @(posedge clk) begin
    if (alloc) dest_mem[alloc_idx] <= alloc_dest;
  end

  always_ff @(posedge clk) begin
    if (cmp_hit) val_mem[cmp_idx] <= cmp_value;
  end

  // Per-slot status flops; cleared together on a flush
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush_all) begin
        live_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
      end else if (alloc && alloc_idx == IDX_W'(i)) begin
        live_q[i] <= 1'b1;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
      end else if (release_head && head_idx == IDX_W'(i)) begin
        live_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
      end else if (cmp_hit && cmp_idx == IDX_W'(i)) begin
        done_q[i] <= 1'b1;
        exc_q[i]  <= cmp_exc;
      end
    end
  end

  assign head_live  = live_q[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_exc   = exc_q[head_idx];
  assign head_dest  = dest_mem[head_idx];
  assign head_value = val_mem[head_idx];

  // R4
  cmp_marks_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && !flush_all && !(release_head && head_idx == cmp_idx))
      |=> done_q[$past(cmp_idx)]);

endmodule

// File: rtl/rob_retire_port.sv
module rob_retire_port #(
  parameter int TAG_W  = 4,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_retire,
  input  logic              do_flush,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic [REG_W-1:0]  head_dest,
  input  logic [DATA_W-1:0] head_value,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [REG_W-1:0]  ret_dest,
  output logic [DATA_W-1:0] ret_value,
  output logic              flush
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      flush     <= 1'b0;
      ret_tag   <= '0;
      ret_dest  <= '0;
      ret_value <= '0;
    end else begin
      ret_valid <= do_retire;
      flush     <= do_flush;
      if (do_retire) begin
        ret_tag   <= head_tag;
        ret_dest  <= head_dest;
        ret_value <= head_value;
      end
    end
  end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [REG_W-1:0]  disp_dest,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [REG_W-1:0]  ret_dest,
  output logic [DATA_W-1:0] ret_value,
  output logic              flush
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [TAG_W-1:0] MAX_TAG = TAG_W'(DEPTH);

  head_act_e         act;
  logic [IDX_W-1:0]  head_q;
  logic [IDX_W-1:0]  tail_q;
  logic [CNT_W-1:0]  count_q;
  logic              full_q;
  logic              alloc;
  logic              cmp_we;
  logic [IDX_W-1:0]  cmp_idx;
  logic              head_live;
  logic              head_done;
  logic              head_exc;
  logic [REG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_value;
  logic [TAG_W-1:0]  head_tag;

  always_comb begin
    act = HEAD_HOLD;
    if (head_live && head_done) act = head_exc ? HEAD_FLUSH : HEAD_RETIRE;
  end

  assign alloc    = disp_valid && !full_q && (act != HEAD_FLUSH);
  assign cmp_we   = cmp_valid && (cmp_tag != '0) && (cmp_tag <= MAX_TAG)
                    && (act != HEAD_FLUSH);
  assign cmp_idx  = IDX_W'(cmp_tag - TAG_W'(1));
  assign head_tag = TAG_W'(head_q) + TAG_W'(1);

  assign disp_ready = !full_q;
  assign disp_tag   = TAG_W'(tail_q) + TAG_W'(1);

  rob_ptr_ctrl #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .alloc   (alloc),
    .act     (act),
    .head_q  (head_q),
    .tail_q  (tail_q),
    .count_q (count_q),
    .full_q  (full_q)
  );

  rob_store #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .flush_all    (act == HEAD_FLUSH),
    .alloc        (alloc),
    .alloc_idx    (tail_q),
    .alloc_dest   (disp_dest),
    .cmp_we       (cmp_we),
    .cmp_idx      (cmp_idx),
    .cmp_value    (cmp_value),
    .cmp_exc      (cmp_exc),
    .release_head (act == HEAD_RETIRE),
    .head_idx     (head_q),
    .head_live    (head_live),
    .head_done    (head_done),
    .head_exc     (head_exc),
    .head_dest    (head_dest),
    .head_value   (head_value)
  );

  rob_retire_port #(
    .TAG_W  (TAG_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_ret (
    .clk        (clk),
    .rst        (rst),
    .do_retire  (act == HEAD_RETIRE),
    .do_flush   (act == HEAD_FLUSH),
    .head_tag   (head_tag),
    .head_dest  (head_dest),
    .head_value (head_value),
    .ret_valid  (ret_valid),
    .ret_tag    (ret_tag),
    .ret_dest   (ret_dest),
    .ret_value  (ret_value),
    .flush      (flush)
  );

  // R7
  retire_flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !ret_valid);

  // R7
  flush_restart_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (disp_tag == TAG_W'(1)) && disp_ready);

  // R5
  ret_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && $past(ret_valid)) |->
      (ret_tag == (($past(ret_tag) == MAX_TAG) ? TAG_W'(1) : $past(ret_tag) + TAG_W'(1))));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ret_valid && !flush));

endmodule

// File: tb/reorder_buf_bench.sv
module reorder_buf_bench;

  localparam int DEPTH  = 8;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              disp_valid = 1'b0;
  logic [REG_W-1:0]  disp_dest = '0;
  logic              disp_ready;
  logic [TAG_W-1:0]  disp_tag;
  logic              cmp_valid = 1'b0;
  logic [TAG_W-1:0]  cmp_tag = '0;
  logic [DATA_W-1:0] cmp_value = '0;
  logic              cmp_exc = 1'b0;
  logic              ret_valid;
  logic [TAG_W-1:0]  ret_tag;
  logic [REG_W-1:0]  ret_dest;
  logic [DATA_W-1:0] ret_value;
  logic              flush;

  always #5 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_reorder_buf (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_dest(disp_dest),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value), .cmp_exc(cmp_exc),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dest(ret_dest),
    .ret_value(ret_value), .flush(flush)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Bench model of slot states
  bit      m_live [DEPTH];
  bit      m_done [DEPTH];
  bit      m_exc  [DEPTH];
  int      m_dest [DEPTH];
  longint  m_val  [DEPTH];
  int      m_head, m_tail, m_cnt;
  bit      e_rv, e_fl;
  int      e_rt, e_rd;
  longint  e_rval;

  function automatic int nxt(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  function automatic bit head_will_flush();
    return m_cnt > 0 && m_done[m_head] && m_exc[m_head];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_live[i] = 0; m_done[i] = 0; m_exc[i] = 0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0;
    e_rv = 0; e_fl = 0;
  endtask

  // Applies one clock edge to the model, using the inputs being driven
  task automatic model_edge();
    bit do_fl, do_rt;
    int pre_cnt;
    do_fl   = head_will_flush();
    do_rt   = m_cnt > 0 && m_done[m_head] && !m_exc[m_head];
    pre_cnt = m_cnt;
    e_rv = 0; e_fl = 0;
    if (do_fl) begin
      e_fl = 1;
      model_reset();
      e_fl = 1;
    end else begin
      if (cmp_valid && cmp_tag != 0 && cmp_tag <= DEPTH && m_live[cmp_tag-1]) begin
        m_done[cmp_tag-1] = 1;
        m_exc[cmp_tag-1]  = cmp_exc;
        m_val[cmp_tag-1]  = cmp_value;
      end
      if (disp_valid && pre_cnt < DEPTH) begin
        m_live[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0;
        m_dest[m_tail] = disp_dest;
        m_tail = nxt(m_tail);
        m_cnt++;
      end
      if (do_rt) begin
        e_rv = 1; e_rt = m_head + 1; e_rd = m_dest[m_head]; e_rval = m_val[m_head];
        m_live[m_head] = 0; m_done[m_head] = 0;
        m_head = nxt(m_head);
        m_cnt--;
      end
    end
  endtask

  task automatic compare();
    chk(disp_ready == (m_cnt < DEPTH), "R3 disp_ready", disp_ready, m_cnt < DEPTH);
    chk(disp_tag == m_tail + 1, "R2 disp_tag", disp_tag, m_tail + 1);
    chk(ret_valid == e_rv, "R5/R6 ret_valid", ret_valid, e_rv);
    chk(flush == e_fl, "R7 flush", flush, e_fl);
    if (e_rv && ret_valid) begin
      chk(ret_tag == e_rt, "R5 ret_tag", ret_tag, e_rt);
      chk(ret_dest == e_rd, "R5 ret_dest", ret_dest, e_rd);
      chk(ret_value == e_rval, "R4 ret_value", ret_value, e_rval);
    end
  endtask

  // Called at a negedge with inputs set; returns at the next negedge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    disp_valid = 0; cmp_valid = 0; cmp_exc = 0;
  endtask

  task automatic set_disp(int dest);
    disp_valid = 1; disp_dest = REG_W'(dest);
  endtask

  task automatic set_cmp(int tag, longint val, bit exc);
    cmp_valid = 1; cmp_tag = TAG_W'(tag); cmp_value = DATA_W'(val); cmp_exc = exc;
  endtask

  // Completes the oldest pending slots in order until the buffer is empty
  task automatic drain();
    int guard = 0;
    while (m_cnt > 0 && guard < 100) begin
      for (int k = 0, p = m_head; k < DEPTH; k++, p = nxt(p)) begin
        if (m_live[p] && !m_done[p]) begin
          set_cmp(p + 1, 1000 + p, 0);
          break;
        end
      end
      tick();
      guard++;
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle state after reset
    chk(disp_ready == 1, "R1 disp_ready", disp_ready, 1);
    chk(disp_tag == 1, "R1 disp_tag", disp_tag, 1);
    chk(ret_valid == 0, "R1 ret_valid", ret_valid, 0);
    chk(flush == 0, "R1 flush", flush, 0);

    // R6: younger slots done, oldest not done
    set_disp(1); tick();
    set_disp(2); tick();
    set_disp(3); tick();
    set_cmp(3, 33, 0); tick();
    set_cmp(2, 22, 0); tick();
    tick();
    chk(ret_valid == 0, "R6 no retire past pending head", ret_valid, 0);
    set_cmp(1, 11, 0); tick();
    tick();
    chk(ret_valid && ret_tag == 1 && ret_value == 11, "R5 first retire", ret_tag, 1);
    tick();
    chk(ret_valid && ret_tag == 2 && ret_value == 22, "R5 second retire", ret_tag, 2);
    tick();
    chk(ret_valid && ret_tag == 3 && ret_value == 33, "R5 third retire", ret_tag, 3);
    tick();

    // R3: fill, then an extra dispatch is ignored
    for (int i = 0; i < DEPTH; i++) begin
      set_disp(i + 4); tick();
    end
    chk(disp_ready == 0, "R3 full", disp_ready, 0);
    begin
      logic [TAG_W-1:0] t0;
      t0 = disp_tag;
      set_disp(30); tick();
      chk(disp_tag == t0, "R3 dispatch ignored when full", disp_tag, t0);
    end

    // R9: retire from full, then dispatch together with a retirement
    set_cmp(m_head + 1, 500, 0); tick();
    set_disp(9); tick();
    chk(disp_ready == 1, "R9 ready after retire from full", disp_ready, 1);
    set_cmp(m_head + 1, 501, 0); tick();
    begin
      logic [TAG_W-1:0] t1;
      t1 = disp_tag;
      set_disp(10); tick();
      chk(disp_ready == 1, "R9 occupancy kept on dispatch+retire", disp_ready, 1);
      chk(disp_tag == ((t1 == DEPTH) ? 1 : t1 + 1), "R9 tag advanced", disp_tag, t1 + 1);
    end
    set_disp(11); tick();
    chk(disp_ready == 0, "R9 full again", disp_ready, 0);
    drain();
    tick(); tick();

    // R7, R8: exception at the head, dispatch and result in the flush cycle
    set_disp(12); tick();
    set_disp(13); tick();
    set_cmp(m_head + 1, 77, 1); tick();
    set_disp(14);
    set_cmp(nxt(m_head) + 1, 88, 0);
    tick();
    chk(flush == 1, "R7 flush pulse", flush, 1);
    chk(disp_tag == 1, "R8 dispatch dropped in flush cycle", disp_tag, 1);
    chk(disp_ready == 1, "R7 empty after flush", disp_ready, 1);
    tick(); tick();
    chk(ret_valid == 0, "R8 result dropped, nothing retires", ret_valid, 0);

    // Random phase
    void'($urandom(32'h5eed_1234));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (($urandom % 100) < 60) set_disp($urandom % 32);
      if (($urandom % 100) < 55 && !head_will_flush()) begin
        int start;
        start = $urandom % DEPTH;
        for (int k = 0; k < DEPTH; k++) begin
          int p;
          p = (start + k) % DEPTH;
          if (m_live[p] && !m_done[p]) begin
            set_cmp(p + 1, $urandom, (($urandom % 60) == 0));
            break;
          end
        end
      end else if (($urandom % 100) < 20) begin
        set_cmp($urandom % (DEPTH + 1), $urandom, 0);
        if (cmp_tag != 0 && m_live[cmp_tag-1] && m_done[cmp_tag-1]) cmp_valid = 0;
      end
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule